// File: doc/BRIEF.md
# Miss and Write Buffer Allocator

This block hands out entries from two small pools that sit beside a cache: a pool that tracks outstanding misses and a pool that holds pending writes. Each cycle it accepts at most one allocation request. The request carries a kind code, an address, a size and three attribute flags. The block sorts the request into a pool, adjusts the stored address and size for that kind, and places it in the lowest-numbered free entry. It stamps the entry with a global sequence number that both pools share.

The block reports pool pressure to an external blocking tracker through one-cycle strobes. A set strobe fires when an allocation fills a pool. A clear strobe fires when a pool leaves the full condition. When the requester asks for it, the block also raises a downstream bus request that names the pool.

Each entry is a three-state machine:
- `ENT_FREE`: the entry holds nothing.
- `ENT_WAIT`: the entry is allocated and waiting to be issued.
- `ENT_BUSY`: the entry has been issued and is in service.

The transitions are:
- *claim*: `ENT_FREE` to `ENT_WAIT`, on allocation.
- *launch*: `ENT_WAIT` to `ENT_BUSY`, on an issue command.
- *launch-and-drop*: `ENT_WAIT` to `ENT_FREE`, on an issue command whose drop flag is set, for issues that expect no response.
- *retire*: `ENT_BUSY` to `ENT_FREE`, on completion.

A lookup port shows any entry's state and contents without delay.

Top module: `mwb_alloc`

## Requirements
- R1: A request of kind 0 (cacheable miss) with `req_uncache`=0 is stored in pool 0. Its address is stored as `req_addr` AND NOT (BLK_BYTES-1), and its size is stored as BLK_BYTES.
- R2: A request of kind 1 (write) with `req_wr`=1 and `req_rd`=0 is stored in pool 1 with the exact address and size given.
- R3: A request of kind 2 (uncached read) with `req_uncache`=1 and `req_rd`=1 is stored in pool 0 with the exact address and size, with no alignment.
- R4: Accepted allocations are numbered from 0 after reset, rising by 1 per acceptance across both pools. One cycle after acceptance, `ack_valid` pulses and reports the pool, the index of the lowest free entry, and the number, which is also stored in the entry.
- R5: `blk_set[p]` pulses one cycle after an accepted allocation that leaves every entry of pool p occupied. Bit 0 is the miss pool and bit 1 is the write pool.
- R6: `blk_clr[p]` pulses one cycle after any cycle in which pool p goes from fully occupied to not fully occupied, whether by an issue with drop or by a completion.
- R7: `bus_req` pulses one cycle after an accepted allocation that had `req_bus`=1. At the same time `bus_cause` gives the pool (0 miss, 1 write). No bus request is raised otherwise.
- R8: `look_state` reads 0 for free, 1 for waiting and 2 for in service. An issue to a waiting entry moves it to in service, or to free when `iss_drop`=1. A completion to an in-service entry frees it. Issue or completion commands aimed at entries in any other state are ignored.
- R9: Any of the following pulses `err_illegal` one cycle later, allocates nothing and leaves the sequence number unchanged: kind 0 with `req_uncache`=1; kind 1 without (`req_wr`=1 and `req_rd`=0); kind 2 without (`req_uncache`=1 and `req_rd`=1); kind 3.
- R10: A legal request whose pool is fully occupied pulses `err_full` one cycle later, allocates nothing and leaves the sequence number unchanged.
- R11: After reset every entry is free, every output pulse is 0 and the sequence number is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Allocation request present |
| req_kind | input | 2 | 0 cacheable miss, 1 write, 2 uncached read, 3 invalid |
| req_addr | input | AW | Request address |
| req_size | input | SW | Request size in bytes |
| req_uncache | input | 1 | Request declares itself uncacheable |
| req_rd | input | 1 | Request reads |
| req_wr | input | 1 | Request writes |
| req_bus | input | 1 | Raise a downstream bus request on acceptance |
| iss_valid | input | 1 | Mark an entry in service |
| iss_pool | input | 1 | Pool of the issued entry |
| iss_idx | input | IW | Index of the issued entry |
| iss_drop | input | 1 | Free the entry on issue (no response expected) |
| cmp_valid | input | 1 | Completion for an in-service entry |
| cmp_pool | input | 1 | Pool of the completed entry |
| cmp_idx | input | IW | Index of the completed entry |
| look_pool | input | 1 | Pool selected for lookup |
| look_idx | input | IW | Entry selected for lookup |
| ack_valid | output | 1 | Allocation accepted (registered pulse) |
| ack_pool | output | 1 | Pool of the accepted allocation |
| ack_idx | output | IW | Entry index used |
| ack_order | output | OW | Sequence number given |
| err_illegal | output | 1 | Illegal request pulse |
| err_full | output | 1 | Full pool refusal pulse |
| blk_set | output | 2 | Blocking-cause set strobes per pool |
| blk_clr | output | 2 | Blocking-cause clear strobes per pool |
| bus_req | output | 1 | Downstream bus request pulse |
| bus_cause | output | 1 | Pool that caused the bus request |
| look_state | output | 2 | State of looked-up entry |
| look_addr | output | AW | Stored address of looked-up entry |
| look_size | output | SW | Stored size of looked-up entry |
| look_order | output | OW | Stored sequence number of looked-up entry |

## Verification
The acknowledge, error, blocking strobe and bus request results come from registers. Each is due exactly one clock edge after the cycle whose inputs caused it. The lookup outputs are combinational on entry state, so an entry shows its new state right after that same edge.

The bench drives each stimulus on a falling edge and lets one rising edge pass. At the next falling edge it compares every pulse output with what its model predicts. It then walks the lookup port across all entries in sub-cycle steps before driving the next stimulus. Because a pulse must also be absent in the cycle after it was due, a result that is early, late or stretched shows up as a mismatch.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

    typedef enum logic [1:0] {
        ENT_FREE = 2'd0,
        ENT_WAIT = 2'd1,
        ENT_BUSY = 2'd2
    } ent_state_e;

    localparam logic [1:0] KIND_MISS   = 2'd0;
    localparam logic [1:0] KIND_WRITE  = 2'd1;
    localparam logic [1:0] KIND_UNC_RD = 2'd2;

    localparam int   NUM_POOLS = 2;
    localparam logic POOL_MISS = 1'b0;
    localparam logic POOL_WB   = 1'b1;

endpackage

// File: rtl/mwb_classify.sv
module mwb_classify
    import mwb_pkg::*;
#(
    parameter int AW        = 32,
    parameter int SW        = 8,
    parameter int BLK_BYTES = 64
) (
    input  logic [1:0]    kind,
    input  logic [AW-1:0] addr_i,
    input  logic [SW-1:0] size_i,
    input  logic          uncache,
    input  logic          rd,
    input  logic          wr,
    output logic          legal,
    output logic          pool,
    output logic [AW-1:0] addr_o,
    output logic [SW-1:0] size_o
);
    localparam logic [AW-1:0] BLK_MASK = AW'(BLK_BYTES - 1);
    localparam logic [SW-1:0] BLK_SIZE = SW'(BLK_BYTES);

    always_comb begin
        legal  = 1'b0;
        pool   = POOL_MISS;
        addr_o = addr_i;
        size_o = size_i;
        unique case (kind)
            KIND_MISS: begin
                legal  = !uncache;
                addr_o = addr_i & ~BLK_MASK;
                size_o = BLK_SIZE;
            end
            KIND_WRITE: begin
                legal = wr && !rd;
                pool  = POOL_WB;
            end
            KIND_UNC_RD: begin
                legal = uncache && rd;
            end
            default: begin
                legal = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mwb_entry.sv
module mwb_entry
    import mwb_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 8,
    parameter int OW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          claim,
    input  logic          launch,
    input  logic          drop,
    input  logic          retire,
    input  logic [AW-1:0] addr_i,
    input  logic [SW-1:0] size_i,
    input  logic [OW-1:0] order_i,
    output ent_state_e    state,
    output logic          occ_next,
    output logic [AW-1:0] addr_q,
    output logic [SW-1:0] size_q,
    output logic [OW-1:0] order_q
);
    ent_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ENT_FREE: if (claim)  st_d = ENT_WAIT;
            ENT_WAIT: if (launch) st_d = drop ? ENT_FREE : ENT_BUSY;
            ENT_BUSY: if (retire) st_d = ENT_FREE;
            default:              st_d = ENT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ENT_FREE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            size_q  <= '0;
            order_q <= '0;
        end else if (st_q == ENT_FREE && claim) begin
            addr_q  <= addr_i;
            size_q  <= size_i;
            order_q <= order_i;
        end
    end

    always_comb begin
        state    = st_q;
        occ_next = (st_d != ENT_FREE);
    end

    // R8: a claimed free entry is waiting in the next cycle
    a_r8_claim_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ENT_FREE && claim) |=> (st_q == ENT_WAIT));

    // R8: a free entry never goes straight to in service
    a_r8_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ENT_FREE) |=> (st_q != ENT_BUSY));

    // R8: the contents of an occupied entry do not change
    a_r8_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ENT_FREE) |=> ($stable(addr_q) && $stable(size_q) && $stable(order_q)));

endmodule

// File: rtl/mwb_pool.sv
module mwb_pool
    import mwb_pkg::*;
#(
    parameter int NE = 4,
    parameter int AW = 32,
    parameter int SW = 8,
    parameter int OW = 16,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] addr_i,
    input  logic [SW-1:0] size_i,
    input  logic [OW-1:0] order_i,
    input  logic          iss_en,
    input  logic [IW-1:0] iss_idx,
    input  logic          iss_drop,
    input  logic          cmp_en,
    input  logic [IW-1:0] cmp_idx,
    input  logic [IW-1:0] look_idx,
    output logic          take,
    output logic [IW-1:0] take_idx,
    output logic          full_now,
    output logic          fill_evt,
    output logic          drain_evt,
    output logic [1:0]    look_state,
    output logic [AW-1:0] look_addr,
    output logic [SW-1:0] look_size,
    output logic [OW-1:0] look_order
);
    ent_state_e    st    [NE];
    logic [AW-1:0] e_ad  [NE];
    logic [SW-1:0] e_sz  [NE];
    logic [OW-1:0] e_or  [NE];
    logic [NE-1:0] occ;
    logic [NE-1:0] occ_nx;

    always_comb begin
        take_idx = '0;
        for (int i = NE - 1; i >= 0; i--) begin
            if (!occ[i]) take_idx = IW'(i);
        end
    end

    assign full_now  = &occ;
    assign take      = req && !full_now;
    assign fill_evt  = take && (&occ_nx);
    assign drain_evt = full_now && !(&occ_nx);

    for (genvar g = 0; g < NE; g++) begin : g_ent
        mwb_entry #(.AW(AW), .SW(SW), .OW(OW)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .claim    (take && (take_idx == IW'(g))),
            .launch   (iss_en && (iss_idx == IW'(g))),
            .drop     (iss_drop),
            .retire   (cmp_en && (cmp_idx == IW'(g))),
            .addr_i   (addr_i),
            .size_i   (size_i),
            .order_i  (order_i),
            .state    (st[g]),
            .occ_next (occ_nx[g]),
            .addr_q   (e_ad[g]),
            .size_q   (e_sz[g]),
            .order_q  (e_or[g])
        );
        assign occ[g] = (st[g] != ENT_FREE);
    end

    always_comb begin
        look_state = 2'(ENT_FREE);
        look_addr  = '0;
        look_size  = '0;
        look_order = '0;
        for (int i = 0; i < NE; i++) begin
            if (look_idx == IW'(i)) begin
                look_state = 2'(st[i]);
                look_addr  = e_ad[i];
                look_size  = e_sz[i];
                look_order = e_or[i];
            end
        end
    end

    // R5: a filling allocation leaves the pool full on the next cycle
    a_r5_fill_then_full: assert property (@(posedge clk) disable iff (!rst_n)
        fill_evt |=> full_now);

    // R6: a draining cycle leaves the pool open on the next cycle
    a_r6_drain_then_open: assert property (@(posedge clk) disable iff (!rst_n)
        drain_evt |=> !full_now);

    // R10: a request into a full pool creates no entry
    a_r10_full_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        (full_now && !iss_en && !cmp_en) |=> full_now);

endmodule

// File: rtl/mwb_alloc.sv
module mwb_alloc
    import mwb_pkg::*;
#(
    parameter int NE        = 4,
    parameter int AW        = 32,
    parameter int SW        = 8,
    parameter int OW        = 16,
    parameter int BLK_BYTES = 64,
    parameter int IW        = (NE > 1) ? $clog2(NE) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic [SW-1:0] req_size,
    input  logic          req_uncache,
    input  logic          req_rd,
    input  logic          req_wr,
    input  logic          req_bus,
    input  logic          iss_valid,
    input  logic          iss_pool,
    input  logic [IW-1:0] iss_idx,
    input  logic          iss_drop,
    input  logic          cmp_valid,
    input  logic          cmp_pool,
    input  logic [IW-1:0] cmp_idx,
    input  logic          look_pool,
    input  logic [IW-1:0] look_idx,
    output logic          ack_valid,
    output logic          ack_pool,
    output logic [IW-1:0] ack_idx,
    output logic [OW-1:0] ack_order,
    output logic          err_illegal,
    output logic          err_full,
    output logic [1:0]    blk_set,
    output logic [1:0]    blk_clr,
    output logic          bus_req,
    output logic          bus_cause,
    output logic [1:0]    look_state,
    output logic [AW-1:0] look_addr,
    output logic [SW-1:0] look_size,
    output logic [OW-1:0] look_order
);
    logic          c_legal;
    logic          c_pool;
    logic [AW-1:0] c_addr;
    logic [SW-1:0] c_size;
    logic [OW-1:0] ord_q;

    logic [NUM_POOLS-1:0] p_take, p_full, p_fill, p_drain;
    logic [IW-1:0]        p_tidx [NUM_POOLS];
    logic [1:0]           p_lst  [NUM_POOLS];
    logic [AW-1:0]        p_lad  [NUM_POOLS];
    logic [SW-1:0]        p_lsz  [NUM_POOLS];
    logic [OW-1:0]        p_lor  [NUM_POOLS];

    logic accepted;

    mwb_classify #(.AW(AW), .SW(SW), .BLK_BYTES(BLK_BYTES)) u_cls (
        .kind    (req_kind),
        .addr_i  (req_addr),
        .size_i  (req_size),
        .uncache (req_uncache),
        .rd      (req_rd),
        .wr      (req_wr),
        .legal   (c_legal),
        .pool    (c_pool),
        .addr_o  (c_addr),
        .size_o  (c_size)
    );

    for (genvar p = 0; p < NUM_POOLS; p++) begin : g_pool
        mwb_pool #(.NE(NE), .AW(AW), .SW(SW), .OW(OW), .IW(IW)) u_pool (
            .clk        (clk),
            .rst_n      (rst_n),
            .req        (req_valid && c_legal && (c_pool == 1'(p))),
            .addr_i     (c_addr),
            .size_i     (c_size),
            .order_i    (ord_q),
            .iss_en     (iss_valid && (iss_pool == 1'(p))),
            .iss_idx    (iss_idx),
            .iss_drop   (iss_drop),
            .cmp_en     (cmp_valid && (cmp_pool == 1'(p))),
            .cmp_idx    (cmp_idx),
            .look_idx   (look_idx),
            .take       (p_take[p]),
            .take_idx   (p_tidx[p]),
            .full_now   (p_full[p]),
            .fill_evt   (p_fill[p]),
            .drain_evt  (p_drain[p]),
            .look_state (p_lst[p]),
            .look_addr  (p_lad[p]),
            .look_size  (p_lsz[p]),
            .look_order (p_lor[p])
        );

        // R5: a set strobe is only seen while its pool is full
        a_r5_set_when_full: assert property (@(posedge clk) disable iff (!rst_n)
            blk_set[p] |-> p_full[p]);

        // R6: a clear strobe follows a full pool that is now open
        a_r6_clr_after_full: assert property (@(posedge clk) disable iff (!rst_n)
            blk_clr[p] |-> (!p_full[p] && $past(p_full[p])));
    end

    assign accepted = |p_take;

    always_ff @(posedge clk) begin
        if (!rst_n) ord_q <= '0;
        else if (accepted) ord_q <= ord_q + OW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid   <= 1'b0;
            ack_pool    <= 1'b0;
            ack_idx     <= '0;
            ack_order   <= '0;
            err_illegal <= 1'b0;
            err_full    <= 1'b0;
            blk_set     <= '0;
            blk_clr     <= '0;
            bus_req     <= 1'b0;
            bus_cause   <= 1'b0;
        end else begin
            ack_valid   <= accepted;
            ack_pool    <= c_pool;
            ack_idx     <= p_tidx[c_pool];
            ack_order   <= ord_q;
            err_illegal <= req_valid && !c_legal;
            err_full    <= req_valid && c_legal && p_full[c_pool];
            blk_set     <= p_fill;
            blk_clr     <= p_drain;
            bus_req     <= accepted && req_bus;
            bus_cause   <= c_pool;
        end
    end

    always_comb begin
        look_state = p_lst[look_pool];
        look_addr  = p_lad[look_pool];
        look_size  = p_lsz[look_pool];
        look_order = p_lor[look_pool];
    end

    // R4: the reported number is one below the running counter
    a_r4_order_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> ((ack_order + OW'(1)) == ord_q));

    // R9, R10: a request has at most one outcome
    a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_valid, err_illegal, err_full}));

    // R7: a bus request comes with an acceptance from the same pool
    a_r7_bus_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (ack_valid && (bus_cause == ack_pool)));

endmodule

// File: tb/mwb_alloc_tb_top.sv
`timescale 1ns/100ps
module mwb_alloc_tb_top;
    localparam int NE  = 4;
    localparam int AW  = 32;
    localparam int SW  = 8;
    localparam int OW  = 16;
    localparam int BLK = 64;
    localparam int IW  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          req_valid = 0, req_uncache = 0, req_rd = 0, req_wr = 0, req_bus = 0;
    logic [1:0]    req_kind = 0;
    logic [AW-1:0] req_addr = 0;
    logic [SW-1:0] req_size = 0;
    logic          iss_valid = 0, iss_pool = 0, iss_drop = 0;
    logic [IW-1:0] iss_idx = 0;
    logic          cmp_valid = 0, cmp_pool = 0;
    logic [IW-1:0] cmp_idx = 0;
    logic          look_pool = 0;
    logic [IW-1:0] look_idx = 0;

    logic          ack_valid, ack_pool, err_illegal, err_full, bus_req, bus_cause;
    logic [IW-1:0] ack_idx;
    logic [OW-1:0] ack_order, look_order;
    logic [1:0]    blk_set, blk_clr, look_state;
    logic [AW-1:0] look_addr;
    logic [SW-1:0] look_size;

    mwb_alloc #(.NE(NE), .AW(AW), .SW(SW), .OW(OW), .BLK_BYTES(BLK)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr), .req_size(req_size),
        .req_uncache(req_uncache), .req_rd(req_rd), .req_wr(req_wr), .req_bus(req_bus),
        .iss_valid(iss_valid), .iss_pool(iss_pool), .iss_idx(iss_idx), .iss_drop(iss_drop),
        .cmp_valid(cmp_valid), .cmp_pool(cmp_pool), .cmp_idx(cmp_idx),
        .look_pool(look_pool), .look_idx(look_idx),
        .ack_valid(ack_valid), .ack_pool(ack_pool), .ack_idx(ack_idx), .ack_order(ack_order),
        .err_illegal(err_illegal), .err_full(err_full), .blk_set(blk_set), .blk_clr(blk_clr),
        .bus_req(bus_req), .bus_cause(bus_cause),
        .look_state(look_state), .look_addr(look_addr), .look_size(look_size), .look_order(look_order)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model
    int            m_st [2][NE];
    int            m_kd [2][NE];
    logic [AW-1:0] m_ad [2][NE];
    logic [SW-1:0] m_sz [2][NE];
    logic [OW-1:0] m_or [2][NE];
    logic [OW-1:0] m_ord = 0;

    bit            e_ack, e_pool, e_ill, e_full, e_bus, e_cause;
    int            e_idx;
    logic [OW-1:0] e_ord;
    logic [1:0]    e_set, e_clr;

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic string kind_tag(input int k);
        if (k == 0) return "R1";
        if (k == 1) return "R2";
        return "R3";
    endfunction

    function automatic bit pool_full(input int p);
        int c = 0;
        for (int i = 0; i < NE; i++) if (m_st[p][i] != 0) c++;
        return (c == NE);
    endfunction

    task automatic scan();
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < NE; i++) begin
                look_pool = 1'(p);
                look_idx  = IW'(i);
                #0.5;
                chk("R8", "entry state", look_state, m_st[p][i]);
                if (m_st[p][i] != 0) begin
                    chk(kind_tag(m_kd[p][i]), "stored addr", look_addr, m_ad[p][i]);
                    chk(kind_tag(m_kd[p][i]), "stored size", look_size, m_sz[p][i]);
                    chk("R4", "stored order", look_order, m_or[p][i]);
                end
            end
        end
    endtask

    task automatic step(input bit rv, input logic [1:0] kd, input logic [AW-1:0] ad,
                        input logic [SW-1:0] sz, input bit un, input bit rd, input bit wr,
                        input bit bs, input bit iv, input bit ip, input int ii, input bit idp,
                        input bit cv, input bit cp, input int ci);
        bit lg, pl, ih, ch;
        logic [AW-1:0] ca;
        logic [SW-1:0] cs;
        bit [1:0] fb, fa;
        int j;
        req_valid = rv; req_kind = kd; req_addr = ad; req_size = sz;
        req_uncache = un; req_rd = rd; req_wr = wr; req_bus = bs;
        iss_valid = iv; iss_pool = ip; iss_idx = IW'(ii); iss_drop = idp;
        cmp_valid = cv; cmp_pool = cp; cmp_idx = IW'(ci);

        lg = 0; pl = 0; ca = ad; cs = sz;
        case (kd)
            2'd0: begin lg = !un; ca = ad & ~AW'(BLK - 1); cs = SW'(BLK); end
            2'd1: begin lg = wr && !rd; pl = 1; end
            2'd2: lg = un && rd;
            default: lg = 0;
        endcase
        for (int p = 0; p < 2; p++) fb[p] = pool_full(p);
        j = -1;
        for (int i = NE - 1; i >= 0; i--) if (m_st[pl][i] == 0) j = i;
        e_ack = 0; e_ill = 0; e_full = 0; e_bus = 0;
        if (rv) begin
            if (!lg) e_ill = 1;
            else if (fb[pl]) e_full = 1;
            else e_ack = 1;
        end
        ih = iv && (m_st[ip][ii] == 1);
        ch = cv && (m_st[cp][ci] == 2);
        if (ih) m_st[ip][ii] = idp ? 0 : 2;
        if (ch) m_st[cp][ci] = 0;
        if (e_ack) begin
            m_st[pl][j] = 1; m_kd[pl][j] = int'(kd);
            m_ad[pl][j] = ca; m_sz[pl][j] = cs; m_or[pl][j] = m_ord;
            e_pool = pl; e_idx = j; e_ord = m_ord;
            m_ord = m_ord + 1'b1;
            e_bus = bs; e_cause = pl;
        end
        for (int p = 0; p < 2; p++) begin
            fa[p] = pool_full(p);
            e_set[p] = e_ack && (pl == 1'(p)) && fa[p];
            e_clr[p] = fb[p] && !fa[p];
        end

        @(posedge clk);
        @(negedge clk);
        chk("R4", "ack_valid", ack_valid, e_ack);
        if (e_ack) begin
            chk("R4", "ack_pool", ack_pool, e_pool);
            chk("R4", "ack_idx", ack_idx, e_idx);
            chk("R4", "ack_order", ack_order, e_ord);
        end
        chk("R9", "err_illegal", err_illegal, e_ill);
        chk("R10", "err_full", err_full, e_full);
        chk("R5", "blk_set", blk_set, e_set);
        chk("R6", "blk_clr", blk_clr, e_clr);
        chk("R7", "bus_req", bus_req, e_bus);
        if (e_bus) chk("R7", "bus_cause", bus_cause, e_cause);
        scan();
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    endtask

    initial begin
        #(64'd4_000_000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < NE; i++) m_st[p][i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        chk("R11", "ack_valid", ack_valid, 0);
        chk("R11", "errors", {err_illegal, err_full}, 0);
        chk("R11", "strobes", {blk_set, blk_clr}, 0);
        chk("R11", "bus_req", bus_req, 0);
        scan();

        // R1 aligned miss with bus request, first order number 0
        step(1, 0, 32'h1234_5678, 8'd4, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        // R2 write kept exact, cause 1
        step(1, 1, 32'h0000_A013, 8'd3, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        // R3 uncached read kept exact
        step(1, 2, 32'h0000_1003, 8'd4, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R9 illegal forms
        step(1, 0, 32'h40, 8'd8, 1, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 32'h80, 8'd8, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 2, 32'hC0, 8'd8, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 3, 32'hC0, 8'd8, 1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        // R5 fill miss pool: fourth occupant sets strobe
        step(1, 0, 32'h0000_2FFF, 8'd1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 0, 32'h0000_3041, 8'd1, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        // R10 full refusal
        step(1, 2, 32'h0000_5555, 8'd2, 1, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        // R8 issue without drop: no clear
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0);
        // R8 completion on a waiting entry is ignored
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        // R6 completion frees and clears
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1);
        // R8 issue to a free write entry is ignored
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 3, 0, 0, 0, 0);
        // fill write pool, then drop-issue clears it (R6)
        step(1, 1, 32'h100, 8'd8, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 32'h200, 8'd8, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 32'h300, 8'd8, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 2, 1, 0, 0, 0);
        idle();

        // constrained random phase
        for (int n = 0; n < 3000; n++) begin
            bit rv, un, rd, wr, bs, iv, ip, idp, cv, cp;
            logic [1:0] kd;
            int r, ii, ci;
            rv = ($urandom % 10) < 6;
            r  = $urandom % 20;
            kd = (r == 0) ? 2'd3 : 2'($urandom % 3);
            un = 0; rd = 0; wr = 0;
            case (kd)
                2'd0: begin un = ($urandom % 8) == 0; rd = 1; end
                2'd1: begin wr = 1; rd = ($urandom % 8) == 0; end
                2'd2: begin un = ($urandom % 8) != 0; rd = 1; end
                default: begin un = 1'($urandom); rd = 1'($urandom); wr = 1'($urandom); end
            endcase
            bs  = 1'($urandom);
            iv  = ($urandom % 10) < 4;
            ip  = 1'($urandom);
            ii  = int'($urandom % NE);
            idp = ($urandom % 10) < 3;
            cv  = ($urandom % 10) < 4;
            cp  = 1'($urandom);
            ci  = int'($urandom % NE);
            step(rv, kd, $urandom, SW'($urandom), un, rd, wr, bs, iv, ip, ii, idp, cv, cp, ci);
        end
        idle();

        finished = 1;
        summary();
        $finish;
    end

endmodule